// File: doc/BRIEF.md
# Edge and Quadrature Event Counter

This block is a register-mapped 16-bit counter of external events. It has two inputs, A and B. In plain counting mode it counts upward on the selected edges of input A only. In quadrature mode it treats A and B as the two phases of an incremental encoder, and it counts up or down by the phase order. A single edge-selection field serves both modes. With both edges selected the encoder counts four steps per input cycle. With a single edge selected it counts two steps per input cycle.

Software reaches the block through a single-port register interface. A write happens on a clock edge when `wr_en` is high. A read is combinational from `addr`. The register addresses are: control 0, configuration 1, ceiling 2, compare 3, status 4, flag-clear 5 and count 6. The count runs continuously between zero and the programmed ceiling. It wraps in both directions. The ceiling and compare registers accept writes only while the block is enabled. Each accepted write raises a ready flag, and software clears that flag by writing the flag-clear register.

Both inputs pass through a two-flop synchroniser and then an edge detector. A change on a pin therefore reaches the count on the third rising clock edge after it is first sampled.

Top module: `edge_quad_counter`

## Requirements
- R1: After reset, control reads 0, configuration reads 0, ceiling reads 0xFFFF, compare reads 0, status reads 0 and the count reads 0.
- R2: A write to the ceiling (addr 2) or the compare register (addr 3) while control bit 0 (enable) is clear leaves that register unchanged and sets no status flag.
- R3: An accepted ceiling write sets status bit 0. An accepted compare write sets status bit 1. Writing a 1 to bit 0 or bit 1 of the flag-clear register (addr 5) clears the matching flag, and a 0 in a bit leaves that flag unchanged.
- R4: Counting starts only when control is written with bit 0 = 1 and bit 1 = 1 while enable is already set. Control bit 1 reads back the started state. Before the start, input edges leave the count unchanged.
- R5: With configuration bit 0 = 0 (plain mode), the count increments on edges of input A as selected by configuration bits [2:1]: 0 selects rising edges, 1 selects falling edges, and 2 or 3 selects both edges. The count never decreases in this mode, and input B has no effect.
- R6: An upward step taken while the count is at or above the ceiling gives 0.
- R7: With configuration bit 0 = 1 (quadrature mode) and edge select 2 or 3, every edge of A or B steps the count. The step is upward when A leads B (AB sequence 00, 10, 11, 01) and downward in the reverse order.
- R8: In quadrature mode with edge select 0, only rising edges of A or B step the count, and with edge select 1 only falling edges do. This gives two steps per input cycle in the same directions as in R7.
- R9: A downward step taken at a count of 0 gives the ceiling value.
- R10: A write to the configuration register while enable is set leaves it unchanged.
- R11: Clearing enable sets the count to 0 and clears the started state, so a new start write is needed after the next enable. A disabling control write that falls in the same cycle as a count step takes priority, and the count reads 0 on the next cycle.
- R12: In quadrature mode, a sampled change of both A and B in the same cycle does not step the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken on the rising clock edge |
| addr | input | 3 | Register address for both reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| in_a | input | 1 | Event input A, or encoder phase A |
| in_b | input | 1 | Encoder phase B |

## Verification
A control write that clears enable can land in the same clock cycle that a synchronised edge produces a count step. Both then act on the count register at one edge. The bench sets up this collision by toggling input A and placing the disabling write exactly two edges after the pin is first sampled. It then reads the count in the very next cycle and expects 0. A design that let the step through would show the stepped value for that one cycle.

// File: rtl/eqc_pkg.sv
// Shared types of the edge and quadrature event counter.
// Assumes a 3-bit register address space.
package eqc_pkg;
    localparam int ADDR_W = 3;

    // Register selects; numeric values are the software-visible addresses.
    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_CONF = 3'd1,
        REG_CEIL = 3'd2,
        REG_CMPV = 3'd3,
        REG_STAT = 3'd4,
        REG_FCLR = 3'd5,
        REG_CNT  = 3'd6
    } reg_sel_e;

    // Edge selection shared by plain and quadrature modes.
    typedef enum logic [1:0] {
        EDGE_RISE     = 2'd0,
        EDGE_FALL     = 2'd1,
        EDGE_BOTH     = 2'd2,
        EDGE_BOTH_ALT = 2'd3
    } edge_sel_e;

    // Counting configuration, writable only while disabled.
    typedef struct packed {
        logic      quad;
        edge_sel_e edges;
    } cnt_cfg_t;
endpackage

// File: rtl/eqc_in_sync.sv
// Synchroniser and edge detector for one asynchronous input.
// Assumes STAGES >= 2 and that the pin is low while reset is held,
// because the history flop resets to 0.
module eqc_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              hist_q;

    // Shift the pin through the synchroniser chain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            hist_q <= sync_q[STAGES-1];
        end
    end

    // Edge pulses are one cycle wide, taken from the synchronised level.
    always_comb begin
        level = sync_q[STAGES-1];
        rise  = level & ~hist_q;
        fall  = ~level & hist_q;
    end
endmodule

// File: rtl/eqc_decode.sv
// Turns synchronised edges of A and B into up or down step requests.
// Plain mode counts A only, upward. Quadrature mode decodes the Gray
// order and drops any cycle in which both phases moved.
// Assumes edge pulses are one cycle wide and mutually exclusive per input.
module eqc_decode
    import eqc_pkg::*;
(
    input  cnt_cfg_t cfg,
    input  logic     a_lvl,
    input  logic     a_rise,
    input  logic     a_fall,
    input  logic     b_lvl,
    input  logic     b_rise,
    input  logic     b_fall,
    output logic     step_up,
    output logic     step_dn
);
    logic a_chg, b_chg, a_hit, b_hit;
    logic both_edges;

    // Qualify each input's edge against the shared edge selection.
    always_comb begin
        both_edges = cfg.edges[1];
        a_chg = a_rise | a_fall;
        b_chg = b_rise | b_fall;
        a_hit = both_edges ? a_chg : ((cfg.edges == EDGE_FALL) ? a_fall : a_rise);
        b_hit = both_edges ? b_chg : ((cfg.edges == EDGE_FALL) ? b_fall : b_rise);
    end

    // Choose direction: plain mode is always up; quadrature follows phase order.
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        if (!cfg.quad) begin
            step_up = a_hit;
        end else if (a_chg && !b_chg) begin
            step_up = a_hit & (a_lvl != b_lvl);
            step_dn = a_hit & (a_lvl == b_lvl);
        end else if (b_chg && !a_chg) begin
            step_up = b_hit & (b_lvl == a_lvl);
            step_dn = b_hit & (b_lvl != a_lvl);
        end
    end
endmodule

// File: rtl/eqc_count.sv
// Count register: wraps between 0 and the ceiling in both directions.
// Stop (enable low, or a disabling write this cycle) beats any step.
// Assumes step_up and step_dn are never high together.
module eqc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             stop_now,
    input  logic             started,
    input  logic [CNT_W-1:0] ceil,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [CNT_W-1:0] cnt
);
    // Advance, wrap or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_en || stop_now) begin
            cnt <= '0;
        end else if (started) begin
            if (step_up)
                cnt <= (cnt >= ceil) ? '0 : cnt + 1'b1;
            else if (step_dn)
                cnt <= (cnt == '0) ? ceil : cnt - 1'b1;
        end
    end

    a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en || stop_now) |=> (cnt == '0));
    a_r6_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !stop_now && started && step_up && cnt >= ceil) |=> (cnt == '0));
    a_r9_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !stop_now && started && step_dn && cnt == '0) |=> (cnt == $past(ceil)));
    a_r4_hold_unstarted: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !stop_now && !started) |=> $stable(cnt));
endmodule

// File: rtl/eqc_regs.sv
// Register file: control, configuration, ceiling, compare, ready flags,
// flag-clear and count readback. One write port, combinational read.
// Assumes CNT_W >= 3 so the narrow fields fit in the data word.
module eqc_regs
    import eqc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  rdata,
    output logic              run_en,
    output logic              started,
    output logic              stop_now,
    output cnt_cfg_t          cfg,
    output logic [CNT_W-1:0]  ceil
);
    localparam logic [CNT_W-1:0] CEIL_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cmpv_q;
    logic             ceil_ok, cmpv_ok;
    logic             wr_ctrl, wr_conf, wr_ceil, wr_cmpv, wr_fclr;

    // Decode which register the current write targets.
    always_comb begin
        wr_ctrl  = wr_en && (addr == REG_CTRL);
        wr_conf  = wr_en && (addr == REG_CONF);
        wr_ceil  = wr_en && (addr == REG_CEIL);
        wr_cmpv  = wr_en && (addr == REG_CMPV);
        wr_fclr  = wr_en && (addr == REG_FCLR);
        stop_now = wr_ctrl && !wdata[0];
    end

    // Enable and start state; a start needs enable to be set already.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            started <= 1'b0;
        end else if (wr_ctrl) begin
            run_en  <= wdata[0];
            started <= wdata[0] & run_en & (wdata[1] | started);
        end
    end

    // Configuration accepts writes only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '{quad: 1'b0, edges: EDGE_RISE};
        else if (wr_conf && !run_en)
            cfg <= '{quad: wdata[0], edges: edge_sel_e'(wdata[2:1])};
    end

    // Ceiling and compare accept writes only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ceil   <= CEIL_MAX;
            cmpv_q <= '0;
        end else begin
            if (wr_ceil && run_en) ceil   <= wdata;
            if (wr_cmpv && run_en) cmpv_q <= wdata;
        end
    end

    // Ready flags: set by an accepted write, cleared by writing 1 to the flag-clear register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ceil_ok <= 1'b0;
            cmpv_ok <= 1'b0;
        end else begin
            if (wr_ceil && run_en)        ceil_ok <= 1'b1;
            else if (wr_fclr && wdata[0]) ceil_ok <= 1'b0;
            if (wr_cmpv && run_en)        cmpv_ok <= 1'b1;
            else if (wr_fclr && wdata[1]) cmpv_ok <= 1'b0;
        end
    end

    // Read multiplexer; unmapped addresses and the flag-clear register read 0.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: rdata[1:0] = {started, run_en};
            REG_CONF: rdata[2:0] = {cfg.edges, cfg.quad};
            REG_CEIL: rdata      = ceil;
            REG_CMPV: rdata      = cmpv_q;
            REG_STAT: rdata[1:0] = {cmpv_ok, ceil_ok};
            REG_CNT:  rdata      = cnt;
            default:  rdata      = '0;
        endcase
    end

    a_r2_ceil_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ceil && !run_en) |=> $stable(ceil));
    a_r2_cmpv_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmpv && !run_en) |=> $stable(cmpv_q));
    a_r3_ceil_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ceil && run_en) |=> ceil_ok);
    a_r3_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fclr && wdata[1] && !wr_cmpv) |=> !cmpv_ok);
    a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_conf && run_en) |=> $stable(cfg));
    a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(started) |-> $past(run_en));
endmodule

// File: rtl/edge_quad_counter.sv
// Top level: two synchronised inputs, the step decoder, the count register
// and the register file. Assumes in_a and in_b are asynchronous to clk
// and are low while reset is held.
module edge_quad_counter
    import eqc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              in_a,
    input  logic              in_b
);
    localparam int N_IN = 2;

    logic [N_IN-1:0]  pin_v, lvl, rise, fall;
    logic             step_up, step_dn;
    logic             run_en, started, stop_now;
    cnt_cfg_t         cfg;
    logic [CNT_W-1:0] ceil, cnt;

    assign pin_v = {in_b, in_a};

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        eqc_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_v[i]),
            .level (lvl[i]),
            .rise  (rise[i]),
            .fall  (fall[i])
        );
    end

    eqc_decode u_decode (
        .cfg     (cfg),
        .a_lvl   (lvl[0]),
        .a_rise  (rise[0]),
        .a_fall  (fall[0]),
        .b_lvl   (lvl[1]),
        .b_rise  (rise[1]),
        .b_fall  (fall[1]),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    eqc_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .stop_now (stop_now),
        .started  (started),
        .ceil     (ceil),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .cnt      (cnt)
    );

    eqc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt      (cnt),
        .rdata    (rdata),
        .run_en   (run_en),
        .started  (started),
        .stop_now (stop_now),
        .cfg      (cfg),
        .ceil     (ceil)
    );

    a_r5_plain_up_only: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.quad |-> !step_dn);
    a_r5_b_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.quad && !rise[0] && !fall[0]) |-> !step_up);
    a_r12_double_move: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.quad && (rise[0] || fall[0]) && (rise[1] || fall[1])) |-> (!step_up && !step_dn));
    a_r8_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.quad && cfg.edges == EDGE_RISE && (step_up || step_dn)) |-> (rise[0] || rise[1]));
    a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));
endmodule

// File: tb/edge_quad_counter_bench.sv
`timescale 1ns/1ps
module edge_quad_counter_bench;
    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        in_a = 1'b0, in_b = 1'b0;

    int n_cmp = 0, n_bad = 0;
    int exp_cnt = 0, ceil_v = 65535, pol = 0, ph = 0;
    bit running = 0, done = 0;

    always #2.5 clk = ~clk;

    edge_quad_counter u_edge_quad_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .in_a(in_a), .in_b(in_b)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input int exp, input string req);
        @(negedge clk); addr = a; #1;
        n_cmp++;
        if (rdata !== 16'(exp)) begin
            n_bad++;
            $display("FAIL %s: addr %0d got %0d expected %0d", req, a, rdata, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic void model(input int dir);
        if (!running) return;
        if (dir > 0) exp_cnt = (exp_cnt >= ceil_v) ? 0 : exp_cnt + 1;
        else         exp_cnt = (exp_cnt == 0) ? ceil_v : exp_cnt - 1;
    endfunction

    function automatic logic [1:0] phase_ab(input int p);
        case (p)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    // Stop, configure, enable, set ceiling, start.
    task automatic configure(input bit q, input int p, input int c);
        wr(3'd0, 16'd0); running = 0; exp_cnt = 0;
        chk(3'd6, 0, "R11 count zero after stop");
        wr(3'd1, 16'((p << 1) | q)); pol = p;
        wr(3'd0, 16'd1);
        wr(3'd2, 16'(c)); ceil_v = c;
        wr(3'd0, 16'd3); running = 1;
    endtask

    task automatic quad_step(input int dir, input string req);
        logic [1:0] o, n;
        bit rising;
        o = phase_ab(ph);
        ph = (ph + dir + 4) % 4;
        n = phase_ab(ph);
        rising = (o[1] != n[1]) ? n[1] : n[0];
        if (pol >= 2 || (pol == 0 && rising) || (pol == 1 && !rising)) model(dir);
        @(negedge clk); in_a = n[1]; in_b = n[0];
        settle();
        chk(3'd6, exp_cnt, req);
    endtask

    task automatic pulse_a(input string req);
        @(negedge clk); in_a = 1'b1; in_b = ~in_b;
        if (pol == 0 || pol >= 2) model(1);
        settle(); chk(3'd6, exp_cnt, req);
        @(negedge clk); in_a = 1'b0; in_b = ~in_b;
        if (pol == 1 || pol >= 2) model(1);
        settle(); chk(3'd6, exp_cnt, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk(3'd0, 0, "R1 control"); chk(3'd1, 0, "R1 config");
        chk(3'd2, 65535, "R1 ceiling"); chk(3'd3, 0, "R1 compare");
        chk(3'd4, 0, "R1 status"); chk(3'd6, 0, "R1 count");

        // R2 writes while disabled are dropped
        wr(3'd2, 16'd5); chk(3'd2, 65535, "R2 ceiling locked");
        wr(3'd3, 16'd7); chk(3'd3, 0, "R2 compare locked");
        chk(3'd4, 0, "R2 no flags");

        // R4 start together with enable does not start
        wr(3'd1, 16'd0); pol = 0;
        wr(3'd0, 16'd3); chk(3'd0, 1, "R4 not started");
        running = 0; pulse_a("R4 no count before start");
        wr(3'd0, 16'd3); chk(3'd0, 3, "R4 started"); running = 1;

        // R3 ready flags and clearing
        wr(3'd2, 16'd200); ceil_v = 200;
        chk(3'd2, 200, "R3 ceiling taken"); chk(3'd4, 1, "R3 ceiling flag");
        wr(3'd3, 16'd9); chk(3'd3, 9, "R3 compare taken"); chk(3'd4, 3, "R3 both flags");
        wr(3'd5, 16'd1); chk(3'd4, 2, "R3 clear bit0 only");
        wr(3'd5, 16'd0); chk(3'd4, 2, "R3 zero clear no effect");
        wr(3'd5, 16'd2); chk(3'd4, 0, "R3 clear bit1");

        // R10 configuration locked while enabled
        wr(3'd1, 16'd5); chk(3'd1, 0, "R10 config locked");

        // R5 plain mode sweep over all edge selections, B toggling
        for (int p = 0; p < 4; p++) begin
            configure(1'b0, p, 200);
            for (int k = 0; k < 5; k++) pulse_a("R5 plain count");
        end

        // R6 upward wrap
        configure(1'b0, 0, 3);
        for (int k = 0; k < 9; k++) pulse_a("R6 wrap at ceiling");

        // R7 R8 R9 quadrature sweeps: forward then backward across zero
        ph = 0;
        for (int p = 0; p < 4; p++) begin
            configure(1'b1, p, 9);
            for (int k = 0; k < 12; k++) quad_step(1, (p >= 2) ? "R7 4x forward" : "R8 2x forward");
            for (int k = 0; k < 30; k++) quad_step(-1, "R9 backward with wrap");
        end

        // R12 both phases move together: no step
        configure(1'b1, 2, 9);
        quad_step(1, "R7 before double move");
        @(negedge clk); in_a = ~in_a; in_b = ~in_b; ph = (ph + 2) % 4;
        settle(); chk(3'd6, exp_cnt, "R12 double move ignored");
        quad_step(1, "R7 after double move");

        // R11 disabling write collides with a step
        configure(1'b0, 2, 200);
        pulse_a("R11 setup");
        @(negedge clk); in_a = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 3'd0; wdata = 16'd0;
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0; addr = 3'd6; #1;
        n_cmp++;
        if (rdata !== 16'd0) begin
            n_bad++;
            $display("FAIL R11 collision: got %0d expected 0", rdata);
        end
        running = 0; exp_cnt = 0;
        chk(3'd0, 0, "R11 stopped");
        wr(3'd0, 16'd1); chk(3'd0, 1, "R11 start cleared");
        @(negedge clk); in_a = 1'b0; settle();
        chk(3'd6, 0, "R11 no count without new start");
        wr(3'd0, 16'd3); running = 1;
        @(negedge clk); in_a = 1'b1; model(1); settle();
        chk(3'd6, exp_cnt, "R11 counts after restart");

        done = 1;
        summary();
        $finish;
    end
endmodule